// File: doc/BRIEF.md
# Store-Pair Write Sequencer

This block carries out a paired store with a non-temporal hint. It accepts one 32-bit instruction word while idle and decodes the element size, the signed immediate and the three register indices. It reads the base and both source registers over a register-file read interface, or takes the stack pointer as the base. It then forms two target addresses and issues two ordered write beats on a valid/ready memory port.

When the instruction finishes, the block reports completion with a one-cycle done pulse. When it aborts, it reports a one-cycle fault pulse instead, qualified by an undefined-encoding flag or a stack-pointer misalignment flag. An aborted instruction never reaches the memory port. Caches, translation, tag checking and the register file itself lie outside the block.

Top module: `pair_store_seq`

## Requirements
- R1: Bit 30 of the instruction set to 1 marks the encoding undefined. In the cycle after acceptance, fault_o and undef_o are high, sp_fault_o is low, and no write beat is ever issued. This check takes precedence over the stack-pointer check.
- R2: Bit 31 selects the element size: 0 gives 32-bit elements and 1 gives 64-bit elements. For 32-bit elements mem_wide_o is 0, mem_be_o is 8'h0F and mem_wdata_o carries the low 32 bits of the register, zero-extended. For 64-bit elements mem_wide_o is 1, mem_be_o is 8'hFF and mem_wdata_o carries the full register.
- R3: The 7-bit immediate in bits [21:15] is sign-extended and multiplied by 4 (32-bit elements) or by 8 (64-bit elements). The first beat address is the base plus this offset, modulo 2^64.
- R4: The base index is in bits [9:5]. The value 31 selects sp_i as the base; any other value selects the register read through rf_rn_idx_o/rf_rn_data_i. Register data and sp_i are sampled in the cycle after acceptance.
- R5: The second beat address equals the first beat address plus 4 or 8, modulo 2^64.
- R6: The first beat writes the register indexed by bits [4:0]. The second beat writes the register indexed by bits [14:10]. The beats are issued in that order.
- R7: Every beat has mem_nt_o high. mem_tagchk_o is high exactly when the base index is not 31. mem_priv_o equals priv_i as sampled at acceptance.
- R8: With base index 31 and any of sp_i[3:0] nonzero, fault_o and sp_fault_o go high for one cycle and no beat is issued.
- R9: While mem_valid_o is high and mem_ready_i is low, the address, data, byte enables, size and attributes on the memory port hold their values into the next cycle.
- R10: done_o is high for exactly one cycle, the cycle after the second beat is accepted. After that cycle idle_o is high.
- R11: start_i is accepted only while idle_o is high. A start_i pulse during a transfer leaves that transfer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Instruction present |
| insn_i | input | 32 | Instruction word |
| priv_i | input | 1 | Current level is privileged |
| sp_i | input | 64 | Stack pointer value |
| idle_o | output | 1 | Ready to accept an instruction |
| rf_rn_idx_o | output | 5 | Base register index |
| rf_rn_data_i | input | 64 | Base register value |
| rf_rt_idx_o | output | 5 | First source index |
| rf_rt_data_i | input | 64 | First source value |
| rf_rt2_idx_o | output | 5 | Second source index |
| rf_rt2_data_i | input | 64 | Second source value |
| mem_valid_o | output | 1 | Write beat valid |
| mem_ready_i | input | 1 | Write beat accepted |
| mem_addr_o | output | 64 | Beat byte address |
| mem_wdata_o | output | 64 | Beat write data |
| mem_be_o | output | 8 | Byte enables |
| mem_wide_o | output | 1 | 1 for a 64-bit element, 0 for a 32-bit element |
| mem_nt_o | output | 1 | Non-temporal hint |
| mem_tagchk_o | output | 1 | Tag-check attribute |
| mem_priv_o | output | 1 | Privileged attribute |
| done_o | output | 1 | Pair stored (pulse) |
| fault_o | output | 1 | Instruction aborted (pulse) |
| undef_o | output | 1 | Fault cause: undefined encoding |
| sp_fault_o | output | 1 | Fault cause: misaligned stack pointer |

## Verification
The inline assertions check several rules on every cycle. They cover port stability under backpressure, the 4- or 8-byte step between the two beats, the non-temporal hint, the one-cycle done pulse that follows an acceptance, the undefined-encoding fault timing, and the fact that a busy block ignores new starts. Other behaviour is shown only by the bench scenarios, because it needs a model of the register file and the stack pointer. This covers the correct first address for positive, negative and wrapping offsets, the base selection, which registers land in which beat, zero-extension of narrow data, and the precedence between the two fault causes.

// File: rtl/pair_store_pkg.sv
package pair_store_pkg;
  localparam int unsigned XLEN   = 64;
  localparam int unsigned INSN_W = 32;
  localparam int unsigned IDX_W  = 5;
  localparam int unsigned IMM_W  = 7;
  localparam int unsigned BE_W   = XLEN / 8;
  localparam logic [IDX_W-1:0] SP_IDX = '1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CALC, ST_BEAT0, ST_BEAT1, ST_DONE, ST_FAULT
  } seq_state_e;

  typedef struct packed {
    logic             undef;
    logic             wide;
    logic [IMM_W-1:0] imm;
    logic [IDX_W-1:0] rt2;
    logic [IDX_W-1:0] rn;
    logic [IDX_W-1:0] rt;
  } pair_fields_t;
endpackage

// File: rtl/psq_decode.sv
module psq_decode
  import pair_store_pkg::*;
(
  input  logic [INSN_W-1:0] insn_i,
  output pair_fields_t      fields_o
);
  logic unused_fixed;
  assign unused_fixed = ^insn_i[29:22];

  always_comb begin
    fields_o.undef = insn_i[30];
    fields_o.wide  = insn_i[31];
    fields_o.imm   = insn_i[21:15];
    fields_o.rt2   = insn_i[14:10];
    fields_o.rn    = insn_i[9:5];
    fields_o.rt    = insn_i[4:0];
  end
endmodule

// File: rtl/psq_addr.sv
module psq_addr
  import pair_store_pkg::*;
#(
  parameter int unsigned AW = XLEN
) (
  input  logic [AW-1:0]    base_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic             wide_i,
  output logic [AW-1:0]    addr0_o,
  output logic [AW-1:0]    addr1_o
);
  localparam int unsigned NARROW_SH = 2;
  localparam int unsigned WIDE_SH   = 3;

  logic [AW-1:0] imm_sx;
  logic [AW-1:0] offset;
  logic [AW-1:0] step;

  assign imm_sx  = {{(AW-IMM_W){imm_i[IMM_W-1]}}, imm_i};
  assign offset  = wide_i ? (imm_sx << WIDE_SH) : (imm_sx << NARROW_SH);
  assign step    = wide_i ? AW'(1 << WIDE_SH) : AW'(1 << NARROW_SH);
  assign addr0_o = base_i + offset;
  assign addr1_o = addr0_o + step;
endmodule

// File: rtl/psq_fmt.sv
module psq_fmt
  import pair_store_pkg::*;
#(
  parameter int unsigned DW = XLEN
) (
  input  logic            wide_i,
  input  logic [DW-1:0]   reg_i,
  output logic [DW-1:0]   wdata_o,
  output logic [DW/8-1:0] be_o
);
  localparam int unsigned NB = DW / 8;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    localparam bit LOW_HALF = (b < NB / 2);
    if (LOW_HALF) begin : g_lo
      assign be_o[b]          = 1'b1;
      assign wdata_o[8*b+:8]  = reg_i[8*b+:8];
    end else begin : g_hi
      assign be_o[b]          = wide_i;
      assign wdata_o[8*b+:8]  = wide_i ? reg_i[8*b+:8] : 8'h00;
    end
  end
endmodule

// File: rtl/pair_store_seq.sv
module pair_store_seq
  import pair_store_pkg::*;
#(
  parameter int unsigned SP_ALIGN_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [INSN_W-1:0] insn_i,
  input  logic              priv_i,
  input  logic [XLEN-1:0]   sp_i,
  output logic              idle_o,
  output logic [IDX_W-1:0]  rf_rn_idx_o,
  input  logic [XLEN-1:0]   rf_rn_data_i,
  output logic [IDX_W-1:0]  rf_rt_idx_o,
  input  logic [XLEN-1:0]   rf_rt_data_i,
  output logic [IDX_W-1:0]  rf_rt2_idx_o,
  input  logic [XLEN-1:0]   rf_rt2_data_i,
  output logic              mem_valid_o,
  input  logic              mem_ready_i,
  output logic [XLEN-1:0]   mem_addr_o,
  output logic [XLEN-1:0]   mem_wdata_o,
  output logic [BE_W-1:0]   mem_be_o,
  output logic              mem_wide_o,
  output logic              mem_nt_o,
  output logic              mem_tagchk_o,
  output logic              mem_priv_o,
  output logic              done_o,
  output logic              fault_o,
  output logic              undef_o,
  output logic              sp_fault_o
);
  seq_state_e   st_q;
  pair_fields_t dec, f_q;
  logic         priv_q;
  logic [XLEN-1:0] addr0_q, addr1_q, wd0_q, wd1_q;
  logic [BE_W-1:0] be_q;

  logic [XLEN-1:0] base, addr0, addr1, wd0, wd1;
  logic [BE_W-1:0] be0, be1;
  logic            base_is_sp, sp_mis;

  psq_decode u_dec (.insn_i(insn_i), .fields_o(dec));

  assign base_is_sp = (f_q.rn == SP_IDX);
  assign base       = base_is_sp ? sp_i : rf_rn_data_i;
  assign sp_mis     = base_is_sp && (|sp_i[SP_ALIGN_W-1:0]);

  psq_addr #(.AW(XLEN)) u_addr (
    .base_i(base), .imm_i(f_q.imm), .wide_i(f_q.wide),
    .addr0_o(addr0), .addr1_o(addr1)
  );

  psq_fmt #(.DW(XLEN)) u_fmt0 (
    .wide_i(f_q.wide), .reg_i(rf_rt_data_i), .wdata_o(wd0), .be_o(be0)
  );
  psq_fmt #(.DW(XLEN)) u_fmt1 (
    .wide_i(f_q.wide), .reg_i(rf_rt2_data_i), .wdata_o(wd1), .be_o(be1)
  );

  logic unused_be1;
  assign unused_be1 = ^be1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      f_q     <= '0;
      priv_q  <= 1'b0;
      addr0_q <= '0;
      addr1_q <= '0;
      wd0_q   <= '0;
      wd1_q   <= '0;
      be_q    <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          f_q    <= dec;
          priv_q <= priv_i;
          st_q   <= dec.undef ? ST_FAULT : ST_CALC;
        end
        ST_CALC: begin
          if (sp_mis) begin
            st_q <= ST_FAULT;
          end else begin
            addr0_q <= addr0;
            addr1_q <= addr1;
            wd0_q   <= wd0;
            wd1_q   <= wd1;
            be_q    <= be0;
            st_q    <= ST_BEAT0;
          end
        end
        ST_BEAT0: if (mem_ready_i) st_q <= ST_BEAT1;
        ST_BEAT1: if (mem_ready_i) st_q <= ST_DONE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  assign idle_o       = (st_q == ST_IDLE);
  assign rf_rn_idx_o  = f_q.rn;
  assign rf_rt_idx_o  = f_q.rt;
  assign rf_rt2_idx_o = f_q.rt2;
  assign mem_valid_o  = (st_q == ST_BEAT0) || (st_q == ST_BEAT1);
  assign mem_addr_o   = (st_q == ST_BEAT1) ? addr1_q : addr0_q;
  assign mem_wdata_o  = (st_q == ST_BEAT1) ? wd1_q : wd0_q;
  assign mem_be_o     = be_q;
  assign mem_wide_o   = f_q.wide;
  assign mem_nt_o     = 1'b1;
  assign mem_tagchk_o = !base_is_sp;
  assign mem_priv_o   = priv_q;
  assign done_o       = (st_q == ST_DONE);
  assign fault_o      = (st_q == ST_FAULT);
  assign undef_o      = fault_o && f_q.undef;
  assign sp_fault_o   = fault_o && !f_q.undef;

  // R9: memory port is held under backpressure
  a_r9_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_addr_o) &&
      $stable(mem_wdata_o) && $stable(mem_be_o) && $stable(mem_wide_o) &&
      $stable(mem_priv_o) && $stable(mem_tagchk_o));

  // R5: second beat follows first at the element stride
  a_r5_second_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_BEAT0) && mem_ready_i |=> mem_valid_o &&
      (mem_addr_o == $past(mem_addr_o) + XLEN'(mem_wide_o ? 8 : 4)));

  a_r7_nt_hint: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> mem_nt_o);

  a_r10_done_after_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(mem_valid_o && mem_ready_i));

  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && idle_o);

  a_r1_undef_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && idle_o && insn_i[30] |=> fault_o && undef_o && !sp_fault_o && !mem_valid_o);

  a_r8_fault_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> !mem_valid_o && $past(!mem_valid_o));

  a_r11_busy_ignores: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idle_o |=> $stable(mem_wide_o) && $stable(mem_priv_o) && $stable(rf_rt_idx_o));
endmodule

// File: tb/pair_store_seq_bench.sv
`timescale 1ns/1ps
module pair_store_seq_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] insn_i = '0;
  logic        priv_i = 1'b0;
  logic [63:0] sp_i = '0;
  logic        idle_o;
  logic [4:0]  rf_rn_idx_o, rf_rt_idx_o, rf_rt2_idx_o;
  logic [63:0] rf_rn_data_i, rf_rt_data_i, rf_rt2_data_i;
  logic        mem_valid_o, mem_ready_i = 1'b0;
  logic [63:0] mem_addr_o, mem_wdata_o;
  logic [7:0]  mem_be_o;
  logic        mem_wide_o, mem_nt_o, mem_tagchk_o, mem_priv_o;
  logic        done_o, fault_o, undef_o, sp_fault_o;

  int errors = 0;
  int checks = 0;

  always #2.5 clk_i = ~clk_i;

  function automatic logic [63:0] reg_val(input logic [4:0] i);
    return 64'h8000_0000_0000_1000 + {59'd0, i} * 64'h0000_0101_0000_0040;
  endfunction

  assign rf_rn_data_i  = reg_val(rf_rn_idx_o);
  assign rf_rt_data_i  = reg_val(rf_rt_idx_o);
  assign rf_rt2_data_i = reg_val(rf_rt2_idx_o);

  pair_store_seq u_pair_store_seq (.*);

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // fields: opc[32:31] imm[30:24] rt2[23:19] rn[18:14] rt[13:9] sp_lo[8:1] stall[0]
  localparam int NV = 10;
  localparam logic [32:0] VEC [NV] = '{
    {2'd0, 7'h01, 5'd3,  5'd5,  5'd2,  8'h00, 1'b0},
    {2'd2, 7'h40, 5'd7,  5'd9,  5'd8,  8'h00, 1'b1},
    {2'd2, 7'h3F, 5'd30, 5'd31, 5'd0,  8'h00, 1'b0},
    {2'd0, 7'h40, 5'd4,  5'd31, 5'd6,  8'h10, 1'b1},
    {2'd1, 7'h05, 5'd1,  5'd4,  5'd2,  8'h00, 1'b0},
    {2'd3, 7'h05, 5'd1,  5'd31, 5'd2,  8'h08, 1'b0},
    {2'd2, 7'h02, 5'd1,  5'd31, 5'd2,  8'h08, 1'b0},
    {2'd0, 7'h02, 5'd1,  5'd31, 5'd2,  8'h04, 1'b1},
    {2'd0, 7'h3F, 5'd12, 5'd0,  5'd12, 8'h00, 1'b1},
    {2'd2, 7'h00, 5'd29, 5'd31, 5'd1,  8'hF0, 1'b0}
  };

  task automatic run_one(input logic [32:0] v, input logic pv, input logic inject);
    logic [1:0]  opc = v[32:31];
    logic [6:0]  imm = v[30:24];
    logic [4:0]  rt2 = v[23:19], rn = v[18:14], rt = v[13:9];
    logic [63:0] sp = {56'hFFFF_FFFF_FFFF_FF, v[8:1]};
    logic        stall = v[0];
    logic        wide = opc[1];
    logic [63:0] base = (rn == 5'd31) ? sp : reg_val(rn);
    logic [63:0] off = {{57{imm[6]}}, imm} << (wide ? 3 : 2);
    logic [63:0] a0 = base + off;
    logic [63:0] a1 = a0 + (wide ? 64'd8 : 64'd4);
    logic [63:0] d0 = wide ? reg_val(rt) : {32'd0, reg_val(rt)[31:0]};
    logic [63:0] d1 = wide ? reg_val(rt2) : {32'd0, reg_val(rt2)[31:0]};
    logic        misal = (rn == 5'd31) && (sp[3:0] != 4'd0);
    logic [63:0] ba[2], bd[2];
    logic [7:0]  bbe[2];
    logic        bnt[2], btag[2], bpriv[2], bwide[2];
    int beats = 0, acc_cyc = -1, done_cyc = -1;
    logic saw_fault = 0, saw_undef = 0, saw_spf = 0, fin = 0;
    logic prev_stall = 0;
    logic [63:0] prev_a = 0, prev_d = 0;
    @(negedge clk_i);
    start_i = 1'b1; insn_i = {opc, 8'hA4, imm, rt2, rn, rt}; sp_i = sp; priv_i = pv;
    @(negedge clk_i);
    start_i = 1'b0; priv_i = ~pv;
    for (int cyc = 0; cyc < 40 && !fin; cyc++) begin
      mem_ready_i = stall ? (cyc % 3 == 2) : 1'b1;
      if (inject && cyc == 1) begin start_i = 1'b1; insn_i = 32'h80A4_0C67; end
      else start_i = 1'b0;
      #0.5;
      if (prev_stall)
        chk(mem_valid_o && mem_addr_o == prev_a && mem_wdata_o == prev_d, "R9 hold", mem_addr_o, prev_a);
      prev_stall = mem_valid_o && !mem_ready_i;
      prev_a = mem_addr_o; prev_d = mem_wdata_o;
      if (mem_valid_o && mem_ready_i && beats < 2) begin
        ba[beats] = mem_addr_o; bd[beats] = mem_wdata_o; bbe[beats] = mem_be_o;
        bnt[beats] = mem_nt_o; btag[beats] = mem_tagchk_o;
        bpriv[beats] = mem_priv_o; bwide[beats] = mem_wide_o;
        beats++;
        if (beats == 2) acc_cyc = cyc;
      end
      if (done_o) begin done_cyc = cyc; fin = 1; end
      if (fault_o) begin saw_fault = 1; saw_undef = undef_o; saw_spf = sp_fault_o; fin = 1; end
      @(negedge clk_i);
    end
    start_i = 1'b0;
    if (opc[0]) begin
      chk(saw_fault && saw_undef && !saw_spf, "R1 undef fault", {61'd0, saw_fault, saw_undef, saw_spf}, 64'd6);
      chk(beats == 0, "R1 no write", 64'(beats), 64'd0);
    end else if (misal) begin
      chk(saw_fault && saw_spf && !saw_undef, "R8 sp fault", {61'd0, saw_fault, saw_undef, saw_spf}, 64'd5);
      chk(beats == 0, "R8 no write", 64'(beats), 64'd0);
    end else begin
      chk(beats == 2, "R6 beat count", 64'(beats), 64'd2);
      chk(done_cyc == acc_cyc + 1, "R10 done timing", 64'(done_cyc), 64'(acc_cyc + 1));
      chk(ba[0] == a0, "R3 R4 first addr", ba[0], a0);
      chk(ba[1] == a1, "R5 second addr", ba[1], a1);
      chk(bd[0] == d0, "R6 R2 first data", bd[0], d0);
      chk(bd[1] == d1, "R6 R2 second data", bd[1], d1);
      chk(bbe[0] == (wide ? 8'hFF : 8'h0F) && bbe[1] == bbe[0], "R2 byte enables", {56'd0, bbe[1]}, {56'd0, wide ? 8'hFF : 8'h0F});
      chk(bwide[0] == wide && bwide[1] == wide, "R2 size", {63'd0, bwide[0]}, {63'd0, wide});
      chk(bnt[0] && bnt[1], "R7 non-temporal", {63'd0, bnt[1]}, 64'd1);
      chk(btag[0] == (rn != 5'd31) && btag[1] == btag[0], "R7 tag check", {63'd0, btag[0]}, {63'd0, rn != 5'd31});
      chk(bpriv[0] == pv && bpriv[1] == pv, "R7 privileged", {63'd0, bpriv[0]}, {63'd0, pv});
    end
    #0.5;
    chk(!done_o && !fault_o && idle_o, "R10 pulse ends idle", {61'd0, done_o, fault_o, idle_o}, 64'd1);
    mem_ready_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(idle_o && !mem_valid_o && !done_o && !fault_o, "reset state",
        {60'd0, idle_o, mem_valid_o, done_o, fault_o}, 64'h8);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(idle_o && !mem_valid_o, "reset release idle", {62'd0, idle_o, mem_valid_o}, 64'd2);
    for (int k = 0; k < NV; k++) run_one(VEC[k], k[0], 1'b0);
    // R11: start during a stalled transfer is ignored
    run_one({2'd2, 7'h7E, 5'd11, 5'd6, 5'd10, 8'h00, 1'b1}, 1'b1, 1'b1);
    run_one({2'd0, 7'h10, 5'd14, 5'd31, 5'd13, 8'h20, 1'b1}, 1'b0, 1'b1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule